// File: doc/BRIEF.md
# Blade Bring-Up and Thermal Controller

This block sits in a chassis manager and takes a freshly inserted blade from first contact to service. It listens to a one-beat event stream from the blade's management controller. An insertion event starts a fixed sequence. First it asks for the blade's descriptor and waits for the answer, which carries the blade's power request and one port type per backplane link. It then weighs the request against the remaining chassis power budget. If the budget allows, it commands payload power, deducts the request and computes which links have matching port types at both ends. It sends the resulting link-enable mask first to the blade and then to the peer blades.

Once the blade is online, the controller runs a thermal loop. Over-temperature events raise a three-bit fan level one step at a time. A normal-temperature event lowers the level by one step, but only after a hold-off window in which no over-temperature event arrived. A removal event in any state drops the blade at once: its links are disabled, any power it was granted returns to the budget, and the controller goes back to idle. A command that is not accepted within the time-out window parks the controller in a fault state until removal.

Top module: `blade_bringup_ctrl`

## Requirements
- R1: In idle, an insertion event (ev_kind 0) issues a descriptor read command (cmd_op 1, cmd_peer 0, cmd_arg 0). An insertion event in any other state is ignored and issues no command.
- R2: The power check is made right after the descriptor response (rsp_valid). It grants power when rsp_power is less than or equal to budget_left. No power or link command is issued before that response.
- R3: When the request exceeds budget_left, deny goes high and stays high until removal. No power-on or link-enable command is issued, and budget_left is unchanged.
- R4: On a grant, a power-on command (cmd_op 2, cmd_peer 0) carries the request in cmd_arg. budget_left falls by the request in the cycle that command is accepted.
- R5: Link i is enabled when the blade's two-bit type at rsp_ptype[2i+1:2i] equals the peer's type at peer_ptype[2i+1:2i] and is nonzero. The mask is sent in cmd_arg[NLINK-1:0] as a link-enable command (cmd_op 3), first with cmd_peer 0 and then with cmd_peer 1. After the second command is accepted, link_en equals the mask and online is 1.
- R6: While cmd_valid is high and cmd_ready is low, cmd_op and cmd_arg hold their values.
- R7: A command or descriptor response still pending 4096 cycles after its wait began drives fault high. From then on no command is issued until removal.
- R8: A removal event (ev_kind 1) in any state clears link_en, deny, fault and online, returns any granted power to budget_left, and returns to idle.
- R9: While online, an over-temperature event (ev_kind 2) raises fan_level by one, saturating at 7. Temperature events while not online do not change fan_level.
- R10: While online, a normal-temperature event (ev_kind 3) lowers fan_level by one (floor 0) exactly 1024 cycles after it is taken. An over-temperature event inside that window cancels the decrease.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event beat present this cycle |
| ev_kind | input | 2 | 0 insert, 1 remove, 2 over-temperature, 3 normal temperature |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted when high with cmd_valid |
| cmd_op | output | 3 | 1 descriptor read, 2 payload power-on, 3 link enable |
| cmd_peer | output | 1 | 0 addresses the new blade, 1 addresses the peer blades |
| cmd_arg | output | PWR_W | Power request or link mask |
| rsp_valid | input | 1 | Descriptor response beat |
| rsp_power | input | PWR_W | Blade power request |
| rsp_ptype | input | NLINK*PTW | Blade port type per link |
| peer_ptype | input | NLINK*PTW | Peer port type per link |
| link_en | output | NLINK | Enabled backplane links |
| budget_left | output | PWR_W | Remaining power budget |
| deny | output | 1 | Power request refused |
| fault | output | 1 | Handshake time-out |
| online | output | 1 | Blade powered and connected |
| fan_level | output | FAN_W | Fan speed level |

## Verification
The assertions check on every cycle that a stalled command holds steady, and that the budget only falls when a power-on command is accepted. They also check that the fan level moves at most one step, and rises only after an over-temperature event while online. Finally they check that links are enabled only while online, and that deny, fault and online never overlap. The exact command order and link masks can only be shown by the bench's scenarios. So can the restored budget after removal at various points, the 4096-cycle time-out and the 1024-cycle fan hold-off with its cancellation.

// File: rtl/blade_pkg.sv
package blade_pkg;

    typedef enum logic [1:0] {
        EV_INSERT = 2'd0,
        EV_REMOVE = 2'd1,
        EV_HOT    = 2'd2,
        EV_COOL   = 2'd3
    } ev_kind_e;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_READ_INFO = 3'd1,
        OP_POWER_ON  = 3'd2,
        OP_LINK_EN   = 3'd3
    } cmd_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_CMD,
        S_RD_WAIT,
        S_CHECK,
        S_PWR_CMD,
        S_LNK_BLADE,
        S_LNK_PEER,
        S_RUN,
        S_DENIED,
        S_FAULT
    } state_e;

    function automatic logic is_waiting(input state_e s);
        return (s == S_RD_CMD) || (s == S_RD_WAIT) || (s == S_PWR_CMD) ||
               (s == S_LNK_BLADE) || (s == S_LNK_PEER);
    endfunction

endpackage

// File: rtl/blade_link_match.sv
module blade_link_match #(
    parameter int NLINK = 8,
    parameter int PTW   = 2
) (
    input  logic [NLINK*PTW-1:0] local_t,
    input  logic [NLINK*PTW-1:0] remote_t,
    output logic [NLINK-1:0]     match
);

    for (genvar i = 0; i < NLINK; i++) begin : g_lnk
        logic [PTW-1:0] a;
        logic [PTW-1:0] b;
        assign a = local_t[i*PTW +: PTW];
        assign b = remote_t[i*PTW +: PTW];
        assign match[i] = (a != '0) && (a == b);
    end

endmodule

// File: rtl/blade_budget.sv
module blade_budget #(
    parameter int PWR_W       = 16,
    parameter int BUDGET_INIT = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PWR_W-1:0] req,
    input  logic             take,
    input  logic             give,
    input  logic [PWR_W-1:0] give_amt,
    output logic [PWR_W-1:0] left,
    output logic             fits
);

    logic [PWR_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)       left_q <= PWR_W'(BUDGET_INIT);
        else if (give) left_q <= left_q + give_amt;
        else if (take) left_q <= left_q - req;
    end

    assign left = left_q;
    assign fits = (req <= left_q);

endmodule

// File: rtl/blade_fan_ctrl.sv
module blade_fan_ctrl #(
    parameter int FAN_W    = 3,
    parameter int HOLD_CYC = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hot,
    input  logic             cool,
    output logic [FAN_W-1:0] level
);

    localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [FAN_W-1:0] LMAX = '1;

    logic [FAN_W-1:0] level_q;
    logic             pend_q;
    logic [HW-1:0]    cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            pend_q  <= 1'b0;
            cnt_q   <= '0;
        end else if (hot) begin
            if (level_q != LMAX) level_q <= level_q + 1'b1;
            pend_q <= 1'b0;
        end else if (pend_q) begin
            if (cnt_q == HW'(HOLD_CYC - 1)) begin
                pend_q <= 1'b0;
                if (level_q != '0) level_q <= level_q - 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (cool) begin
            pend_q <= 1'b1;
            cnt_q  <= '0;
        end
    end

    assign level = level_q;

endmodule

// File: rtl/blade_bringup_ctrl.sv
module blade_bringup_ctrl
    import blade_pkg::*;
#(
    parameter int NLINK       = 8,
    parameter int PTW         = 2,
    parameter int PWR_W       = 16,
    parameter int BUDGET_INIT = 1000,
    parameter int TMO_CYC     = 4096,
    parameter int HOLD_CYC    = 1024,
    parameter int FAN_W       = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ev_valid,
    input  logic [1:0]           ev_kind,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [2:0]           cmd_op,
    output logic                 cmd_peer,
    output logic [PWR_W-1:0]     cmd_arg,
    input  logic                 rsp_valid,
    input  logic [PWR_W-1:0]     rsp_power,
    input  logic [NLINK*PTW-1:0] rsp_ptype,
    input  logic [NLINK*PTW-1:0] peer_ptype,
    output logic [NLINK-1:0]     link_en,
    output logic [PWR_W-1:0]     budget_left,
    output logic                 deny,
    output logic                 fault,
    output logic                 online,
    output logic [FAN_W-1:0]     fan_level
);

    localparam int TMO_W = $clog2(TMO_CYC + 1);

    state_e               state_q, state_d;
    logic [PWR_W-1:0]     req_q;
    logic [NLINK*PTW-1:0] ptype_q;
    logic [NLINK-1:0]     mask_q, mask_now, link_q;
    logic                 alloc_q;
    logic [TMO_W-1:0]     tmo_q;
    cmd_op_e              op_w;

    logic ins, rm, hs, waiting, progress, expire, fits, take;

    assign ins      = ev_valid && (ev_kind == EV_INSERT);
    assign rm       = ev_valid && (ev_kind == EV_REMOVE);
    assign hs       = cmd_valid && cmd_ready;
    assign waiting  = is_waiting(state_q);
    assign progress = hs || ((state_q == S_RD_WAIT) && rsp_valid);
    assign expire   = waiting && !progress && (tmo_q == TMO_W'(TMO_CYC - 1));
    assign take     = hs && (state_q == S_PWR_CMD) && !rm;

    blade_link_match #(.NLINK(NLINK), .PTW(PTW)) match_i (
        .local_t (ptype_q),
        .remote_t(peer_ptype),
        .match   (mask_now)
    );

    blade_budget #(.PWR_W(PWR_W), .BUDGET_INIT(BUDGET_INIT)) budget_i (
        .clk     (clk),
        .rst     (rst),
        .req     (req_q),
        .take    (take),
        .give    (rm && alloc_q),
        .give_amt(req_q),
        .left    (budget_left),
        .fits    (fits)
    );

    blade_fan_ctrl #(.FAN_W(FAN_W), .HOLD_CYC(HOLD_CYC)) fan_i (
        .clk  (clk),
        .rst  (rst),
        .hot  (ev_valid && (ev_kind == EV_HOT) && online),
        .cool (ev_valid && (ev_kind == EV_COOL) && online),
        .level(fan_level)
    );

    always_comb begin
        state_d = state_q;
        if (rm) begin
            state_d = S_IDLE;
        end else if (expire) begin
            state_d = S_FAULT;
        end else begin
            case (state_q)
                S_IDLE:      if (ins) state_d = S_RD_CMD;
                S_RD_CMD:    if (hs) state_d = S_RD_WAIT;
                S_RD_WAIT:   if (rsp_valid) state_d = S_CHECK;
                S_CHECK:     state_d = fits ? S_PWR_CMD : S_DENIED;
                S_PWR_CMD:   if (hs) state_d = S_LNK_BLADE;
                S_LNK_BLADE: if (hs) state_d = S_LNK_PEER;
                S_LNK_PEER:  if (hs) state_d = S_RUN;
                default:     state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            req_q   <= '0;
            ptype_q <= '0;
            mask_q  <= '0;
            link_q  <= '0;
            alloc_q <= 1'b0;
            tmo_q   <= '0;
        end else begin
            state_q <= state_d;
            if (!waiting || progress || rm) tmo_q <= '0;
            else                            tmo_q <= tmo_q + 1'b1;
            if (state_q == S_RD_WAIT && rsp_valid && !rm) begin
                req_q   <= rsp_power;
                ptype_q <= rsp_ptype;
            end
            if (state_q == S_CHECK) mask_q <= mask_now;
            if (rm) begin
                alloc_q <= 1'b0;
                link_q  <= '0;
            end else begin
                if (take) alloc_q <= 1'b1;
                if (hs && state_q == S_LNK_PEER) link_q <= mask_q;
            end
        end
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_peer  = 1'b0;
        cmd_arg   = '0;
        op_w      = OP_NONE;
        case (state_q)
            S_RD_CMD: begin
                cmd_valid = 1'b1;
                op_w      = OP_READ_INFO;
            end
            S_PWR_CMD: begin
                cmd_valid = 1'b1;
                op_w      = OP_POWER_ON;
                cmd_arg   = req_q;
            end
            S_LNK_BLADE, S_LNK_PEER: begin
                cmd_valid = 1'b1;
                op_w      = OP_LINK_EN;
                cmd_peer  = (state_q == S_LNK_PEER);
                cmd_arg   = PWR_W'(mask_q);
            end
            default: ;
        endcase
    end

    assign cmd_op  = op_w;
    assign link_en = link_q;
    assign deny    = (state_q == S_DENIED);
    assign fault   = (state_q == S_FAULT);
    assign online  = (state_q == S_RUN);

endmodule

// File: rtl/blade_bringup_chk.sv
module blade_bringup_chk #(
    parameter int NLINK       = 8,
    parameter int PWR_W       = 16,
    parameter int BUDGET_INIT = 1000,
    parameter int FAN_W       = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_valid,
    input logic [1:0]       ev_kind,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [2:0]       cmd_op,
    input logic [PWR_W-1:0] cmd_arg,
    input logic [NLINK-1:0] link_en,
    input logic [PWR_W-1:0] budget_left,
    input logic             deny,
    input logic             fault,
    input logic             online,
    input logic [FAN_W-1:0] fan_level
);

    logic rm_ev;
    assign rm_ev = ev_valid && (ev_kind == 2'd1);

    a_r6_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready && !rm_ev) |=>
            (fault || (cmd_valid && $stable(cmd_op) && $stable(cmd_arg))));

    a_r4_budget_drop: assert property (@(posedge clk) disable iff (rst)
        (budget_left < $past(budget_left)) |->
            $past(cmd_valid && cmd_ready && cmd_op == 3'd2 && !rm_ev));

    a_r4_budget_cap: assert property (@(posedge clk) disable iff (rst)
        budget_left <= PWR_W'(BUDGET_INIT));

    a_r5_links_online: assert property (@(posedge clk) disable iff (rst)
        (link_en != '0) |-> online);

    a_r3_deny_quiet: assert property (@(posedge clk) disable iff (rst)
        deny |-> (!cmd_valid && link_en == '0));

    a_r7_fault_quiet: assert property (@(posedge clk) disable iff (rst)
        fault |-> !cmd_valid);

    a_r8_status_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({deny, fault, online}));

    a_r9_fan_rise: assert property (@(posedge clk) disable iff (rst)
        (fan_level > $past(fan_level)) |->
            ($past(ev_valid && ev_kind == 2'd2 && online) && fan_level == $past(fan_level) + 1'b1));

    a_r10_fan_fall: assert property (@(posedge clk) disable iff (rst)
        (fan_level < $past(fan_level)) |-> (fan_level == $past(fan_level) - 1'b1));

endmodule

bind blade_bringup_ctrl blade_bringup_chk #(
    .NLINK(NLINK), .PWR_W(PWR_W), .BUDGET_INIT(BUDGET_INIT), .FAN_W(FAN_W)
) chk_i (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .link_en(link_en), .budget_left(budget_left), .deny(deny), .fault(fault),
    .online(online), .fan_level(fan_level)
);

// File: tb/blade_bringup_ctrl_tb_top.sv
module blade_bringup_ctrl_tb_top;

    localparam int NLINK = 8;
    localparam int PTW   = 2;
    localparam int HOLD  = 1024;
    localparam int BINIT = 1000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1;
    logic ev_valid = 1'b0;
    logic [1:0] ev_kind = 2'd0;
    logic cmd_valid, cmd_peer;
    logic cmd_ready = 1'b0;
    logic [2:0] cmd_op;
    logic [15:0] cmd_arg;
    logic rsp_valid = 1'b0;
    logic [15:0] rsp_power = '0;
    logic [15:0] rsp_ptype = '0;
    logic [15:0] peer_ptype = '0;
    logic [7:0] link_en;
    logic [15:0] budget_left;
    logic deny, fault, online;
    logic [2:0] fan_level;

    blade_bringup_ctrl dut_i (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_peer(cmd_peer), .cmd_arg(cmd_arg), .rsp_valid(rsp_valid),
        .rsp_power(rsp_power), .rsp_ptype(rsp_ptype), .peer_ptype(peer_ptype),
        .link_en(link_en), .budget_left(budget_left), .deny(deny),
        .fault(fault), .online(online), .fan_level(fan_level)
    );

    int n_chk = 0;
    int n_fail = 0;
    int stall_op = 0;
    logic rsp_pend = 1'b0;
    int log_n = 0;
    logic [2:0]  log_op [16];
    logic        log_peer [16];
    logic [15:0] log_arg [16];

    // responder: decides ready for the coming edge and logs accepted commands
    always @(negedge clk) begin
        if (rst) begin
            cmd_ready = 1'b0;
            rsp_valid = 1'b0;
            rsp_pend  = 1'b0;
        end else begin
            rsp_valid = rsp_pend;
            rsp_pend  = 1'b0;
            cmd_ready = (stall_op == 0 || int'(cmd_op) != stall_op) && ($urandom % 4 != 0);
            if (cmd_valid && cmd_ready) begin
                if (log_n < 16) begin
                    log_op[log_n]   = cmd_op;
                    log_peer[log_n] = cmd_peer;
                    log_arg[log_n]  = cmd_arg;
                end
                log_n++;
                if (cmd_op == 3'd1) rsp_pend = 1'b1;
            end
        end
    end

    task automatic at_neg(input int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_ev(input logic [1:0] k);
        at_neg();
        ev_valid = 1'b1;
        ev_kind  = k;
        at_neg();
        ev_valid = 1'b0;
    endtask

    function automatic logic [7:0] exp_mask(input logic [15:0] a, input logic [15:0] b);
        logic [7:0] m = '0;
        for (int i = 0; i < NLINK; i++)
            m[i] = (a[i*PTW +: PTW] != 2'd0) && (a[i*PTW +: PTW] == b[i*PTW +: PTW]);
        return m;
    endfunction

    task automatic bringup(input logic [15:0] pw, input logic [15:0] bt, input logic [15:0] pt);
        at_neg();
        rsp_power  = pw;
        rsp_ptype  = bt;
        peer_ptype = pt;
        log_n      = 0;
        send_ev(2'd0);
        for (int i = 0; i < 300 && !(online || deny || fault); i++) at_neg();
    endtask

    task automatic check_bringup(input logic [15:0] pw, input logic [15:0] bt, input logic [15:0] pt);
        logic [7:0] m = exp_mask(bt, pt);
        if (pw <= 16'(BINIT)) begin
            chk("R2", "grant online", online, 1);
            chk("R2", "command count", log_n, 4);
            chk("R1", "first op", log_op[0], 1);
            chk("R4", "power op", log_op[1], 2);
            chk("R4", "power arg", log_arg[1], pw);
            chk("R4", "budget after grant", budget_left, BINIT - pw);
            chk("R5", "blade link op", {log_op[2], log_peer[2]}, {3'd3, 1'b0});
            chk("R5", "blade link mask", log_arg[2], m);
            chk("R5", "peer link op", {log_op[3], log_peer[3]}, {3'd3, 1'b1});
            chk("R5", "peer link mask", log_arg[3], m);
            chk("R5", "link_en", link_en, m);
        end else begin
            chk("R3", "deny", deny, 1);
            chk("R3", "command count", log_n, 1);
            chk("R3", "budget kept", budget_left, BINIT);
            chk("R3", "links off", link_en, 0);
        end
    endtask

    task automatic remove_and_check();
        send_ev(2'd1);
        chk("R8", "links cleared", link_en, 0);
        chk("R8", "budget restored", budget_left, BINIT);
        chk("R8", "status cleared", {online, deny, fault}, 0);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        at_neg(5);
        rst = 1'b0;
        at_neg();
        chk("reset", "cmd_valid", cmd_valid, 0);
        chk("reset", "budget", budget_left, BINIT);
        chk("reset", "fan", fan_level, 0);
        chk("reset", "status", {online, deny, fault, link_en}, 0);

        // directed grant
        bringup(16'd300, 16'hE4B1, 16'hE4F1);
        check_bringup(16'd300, 16'hE4B1, 16'hE4F1);

        // R1: insertion while online is ignored
        log_n = 0;
        send_ev(2'd0);
        at_neg(10);
        chk("R1", "no command on second insert", log_n, 0);
        chk("R1", "still online", online, 1);

        // R9: rise and saturation
        for (int k = 1; k <= 9; k++) begin
            send_ev(2'd2);
            chk("R9", "fan step", fan_level, (k > 7) ? 7 : k);
        end

        // R10: hold-off decrease
        send_ev(2'd3);
        at_neg(HOLD - 1);
        chk("R10", "fan before hold-off", fan_level, 7);
        at_neg();
        chk("R10", "fan after hold-off", fan_level, 6);

        // R10: cancel by over-temperature
        send_ev(2'd3);
        at_neg(500);
        send_ev(2'd2);
        chk("R10", "fan raised in window", fan_level, 7);
        at_neg(1100);
        chk("R10", "decrease cancelled", fan_level, 7);

        remove_and_check();

        // R9: ignored while not online
        send_ev(2'd2);
        send_ev(2'd3);
        at_neg(HOLD + 10);
        chk("R9", "fan ignores events offline", fan_level, 7);

        // R3: deny
        bringup(16'd1001, 16'h5555, 16'h5555);
        check_bringup(16'd1001, 16'h5555, 16'h5555);
        at_neg(20);
        chk("R3", "deny held", deny, 1);
        remove_and_check();

        // R8: removal after power granted, during link stall
        stall_op = 3;
        bringup(16'd400, 16'hAAAA, 16'hAAAA);
        chk("R4", "budget during link stall", budget_left, BINIT - 400);
        chk("R6", "stalled op held", cmd_op, 3);
        chk("R6", "stalled mask held", cmd_arg, 16'h00FF);
        remove_and_check();

        // R7: time-out
        bringup(16'd200, 16'h0F0F, 16'h0F0F);
        at_neg(3700);
        chk("R7", "no fault before time-out", fault, 0);
        at_neg(200);
        chk("R7", "fault after time-out", fault, 1);
        chk("R7", "no command in fault", cmd_valid, 0);
        chk("R7", "accepted commands", log_n, 2);
        stall_op = 0;
        at_neg(20);
        chk("R7", "fault held", fault, 1);
        remove_and_check();

        // random bring-ups
        for (int it = 0; it < 20; it++) begin
            logic [15:0] pw = 16'($urandom_range(1199, 0));
            logic [15:0] bt = 16'($urandom);
            logic [15:0] pt = bt ^ 16'($urandom & $urandom & $urandom);
            bringup(pw, bt, pt);
            check_bringup(pw, bt, pt);
            remove_and_check();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule